// File: doc/BRIEF.md
# Flash Lock-Bit Set Sequencer

This block sits on the host side of a flash device and carries out one lock-bit set operation for each accepted request. The operation protects either a single block or the whole device through its master lock. The block issues a setup write and a confirm write, then reads the device status until the device reports ready. If the caller asks for a full check, the block reduces the final status byte to one result code. It clears the device's error bits when an error is found and returns the device to array-read mode.

The request port carries a start strobe, a block/master selector, a block address, a defer flag and a limit on the number of status reads. When the defer flag is set, the operation stops once the device is ready. The sticky error bits are then left in place so that one full check can cover a whole batch. The flash side is a single-cycle synchronous bus: a write strobe with address and data, or a read strobe whose data the device returns in the same cycle.

Top module: `lockbit_seq`

## Requirements
- R1: After reset, and whenever no operation is running, `busy`, `done`, `bus_wr` and `bus_rd` are low.
- R2: In the cycle after `req_valid` is accepted in idle, the block writes 0x60. The address is `req_addr` for a block lock (`req_master`=0) or the parameter `DEV_ADDR` for a master lock.
- R3: In the next cycle it writes the confirm byte to the same address: 0x01 for a block lock, 0xF1 for the master lock.
- R4: From the following cycle it reads status on every cycle, at the same address, until a read returns bit 7 = 1.
- R5: A full check decodes the ready status in fixed priority: bit 3 gives code 1, else bit 1 gives code 2, else bits 5 and 4 both set give code 3, else bit 4 gives code 4, otherwise code 0. Bit 5 alone gives code 0.
- R6: A non-zero code from a full check causes a write of 0x50 in the cycle after the ready read, and this write comes before the array-read write.
- R7: A full check ends with a write of 0xFF, in the cycle after the ready read on success or after the 0x50 write on error.
- R8: With `req_defer`=1, the ready read is followed directly by `done` with code 0. No status is decoded and no further write is made, so error bits remain for a later check.
- R9: If `poll_limit` consecutive reads all return bit 7 = 0, the next cycle raises `done` with code 5 and no write is made (`poll_limit` ≥ 1).
- R10: `req_valid` is ignored while `busy` is high.
- R11: `done` is high for exactly one cycle with `result` valid, and the block is idle in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Start strobe, taken only when idle |
| req_master | input | 1 | 1 = master lock, 0 = block lock |
| req_defer | input | 1 | 1 = skip the full status check |
| req_addr | input | AW | Block address |
| poll_limit | input | CW | Maximum number of busy status reads |
| bus_wr | output | 1 | Flash write strobe |
| bus_rd | output | 1 | Flash status read strobe |
| bus_addr | output | AW | Flash address |
| bus_wdata | output | 8 | Flash command byte |
| bus_rdata | input | 8 | Status byte, valid in the read cycle |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 3 | 0 ok, 1 voltage, 2 protect, 3 sequence, 4 lock fail, 5 timeout |

## Verification
The status byte is driven with combinations of error bits, each built so that only a correct priority walk gives the expected code. Examples are voltage together with protect and sequence bits, protect together with the sequence pair, the sequence pair alone, bit 4 alone and bit 5 alone. Busy lengths of zero and several reads, compared against the read limit on both sides of equality, separate an off-by-one timeout from a correct one. A deferred operation with a lock failure pending, followed by a checked one, shows that deferral neither decodes nor clears the sticky bits. A second start strobe in the middle of an operation shows that the bus trace is unchanged.

// File: rtl/lockbit_seq.sv
module lockbit_seq #(
  parameter int AW = 16,
  parameter int CW = 16,
  parameter logic [AW-1:0] DEV_ADDR = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_master,
  input  logic          req_defer,
  input  logic [AW-1:0] req_addr,
  input  logic [CW-1:0] poll_limit,
  output logic          bus_wr,
  output logic          bus_rd,
  output logic [AW-1:0] bus_addr,
  output logic [7:0]    bus_wdata,
  input  logic [7:0]    bus_rdata,
  output logic          busy,
  output logic          done,
  output logic [2:0]    result
);

  localparam logic [7:0] CMD_SETUP  = 8'h60;
  localparam logic [7:0] CMD_BLOCK  = 8'h01;
  localparam logic [7:0] CMD_MASTER = 8'hF1;
  localparam logic [7:0] CMD_CLEAR  = 8'h50;
  localparam logic [7:0] CMD_ARRAY  = 8'hFF;

  localparam logic [2:0] RC_OK      = 3'd0;
  localparam logic [2:0] RC_VOLT    = 3'd1;
  localparam logic [2:0] RC_PROT    = 3'd2;
  localparam logic [2:0] RC_SEQ     = 3'd3;
  localparam logic [2:0] RC_LOCK    = 3'd4;
  localparam logic [2:0] RC_TIMEOUT = 3'd5;

  typedef enum logic [2:0] {
    S_IDLE, S_SETUP, S_CONFIRM, S_POLL, S_CLEAR, S_ARRAY, S_DONE
  } state_t;

  state_t        st;
  logic          master_q;
  logic          defer_q;
  logic [AW-1:0] addr_q;
  logic [CW-1:0] reads_q;
  logic [2:0]    res_q;
  logic [2:0]    code;

  always_comb begin
    if (bus_rdata[3])                     code = RC_VOLT;
    else if (bus_rdata[1])                code = RC_PROT;
    else if (bus_rdata[5] && bus_rdata[4]) code = RC_SEQ;
    else if (bus_rdata[4])                code = RC_LOCK;
    else                                  code = RC_OK;
  end

  assign bus_wr   = (st == S_SETUP) || (st == S_CONFIRM) || (st == S_CLEAR) || (st == S_ARRAY);
  assign bus_rd   = (st == S_POLL);
  assign bus_addr = addr_q;
  assign busy     = (st != S_IDLE);
  assign done     = (st == S_DONE);
  assign result   = res_q;

  always_comb begin
    case (st)
      S_SETUP:   bus_wdata = CMD_SETUP;
      S_CONFIRM: bus_wdata = master_q ? CMD_MASTER : CMD_BLOCK;
      S_CLEAR:   bus_wdata = CMD_CLEAR;
      S_ARRAY:   bus_wdata = CMD_ARRAY;
      default:   bus_wdata = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      master_q <= 1'b0;
      defer_q  <= 1'b0;
      addr_q   <= '0;
      reads_q  <= '0;
      res_q    <= RC_OK;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          master_q <= req_master;
          defer_q  <= req_defer;
          addr_q   <= req_master ? DEV_ADDR : req_addr;
          st       <= S_SETUP;
        end
        S_SETUP:   st <= S_CONFIRM;
        S_CONFIRM: begin
          reads_q <= '0;
          st      <= S_POLL;
        end
        S_POLL: begin
          if (bus_rdata[7]) begin
            if (defer_q) begin
              res_q <= RC_OK;
              st    <= S_DONE;
            end else begin
              res_q <= code;
              st    <= (code != RC_OK) ? S_CLEAR : S_ARRAY;
            end
          end else if (reads_q + CW'(1) == poll_limit) begin
            res_q <= RC_TIMEOUT;
            st    <= S_DONE;
          end else begin
            reads_q <= reads_q + CW'(1);
          end
        end
        S_CLEAR: st <= S_ARRAY;
        S_ARRAY: st <= S_DONE;
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/lockbit_seq_chk.sv
module lockbit_seq_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_wr,
  input logic          bus_rd,
  input logic [AW-1:0] bus_addr,
  input logic [7:0]    bus_wdata,
  input logic          busy,
  input logic          done,
  input logic [2:0]    result
);

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!bus_wr && !bus_rd && !done));

  assert_setup_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (bus_wr && bus_wdata == 8'h60));

  assert_confirm_follows_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_wdata == 8'h60) |=>
      (bus_wr && (bus_wdata == 8'h01 || bus_wdata == 8'hF1) && $stable(bus_addr)));

  assert_read_write_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_rd));

  assert_result_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (result <= 3'd5));

  assert_clear_then_array_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_wdata == 8'h50) |=> (bus_wr && bus_wdata == 8'hFF));

  assert_timeout_after_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && result == 3'd5) |-> $past(bus_rd));

  assert_done_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));

endmodule

bind lockbit_seq lockbit_seq_chk #(.AW(AW)) u_chk (.*);

// File: tb/lockbit_seq_test.sv
`timescale 1ns/1ps
module lockbit_seq_test;
  localparam int AW = 16;
  localparam int CW = 16;
  localparam logic [AW-1:0] DEV = 16'h0000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_master = 1'b0, req_defer = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [CW-1:0] poll_limit = 16'd8;
  logic bus_wr, bus_rd, busy, done;
  logic [AW-1:0] bus_addr;
  logic [7:0] bus_wdata, bus_rdata;
  logic [2:0] result;

  always #2 clk = ~clk;

  lockbit_seq #(.AW(AW), .CW(CW), .DEV_ADDR(DEV)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_master(req_master),
    .req_defer(req_defer), .req_addr(req_addr), .poll_limit(poll_limit),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .busy(busy), .done(done), .result(result));

  // flash device model
  int unsigned fl_busy_len = 0;
  int unsigned fl_left = 0;
  logic [6:0] fl_err = '0;
  assign bus_rdata = (fl_left == 0) ? {1'b1, fl_err} : 8'h00;
  always @(posedge clk) begin
    if (bus_wr && (bus_wdata == 8'h01 || bus_wdata == 8'hF1)) fl_left <= fl_busy_len;
    if (bus_rd && fl_left != 0) fl_left <= fl_left - 1;
    if (bus_wr && bus_wdata == 8'h50) fl_err <= '0;
  end

  typedef struct {
    logic wr; logic rd; logic dn; logic bz;
    logic [AW-1:0] addr; logic [7:0] data; logic [2:0] res; int tag;
  } exp_t;
  exp_t q[$];
  int checks = 0, errors = 0;
  logic live = 1'b0;

  function automatic void push(logic wr, logic rd, logic dn, logic [AW-1:0] a,
                               logic [7:0] d, logic [2:0] r, int tag);
    exp_t e;
    e.wr = wr; e.rd = rd; e.dn = dn; e.bz = 1'b1;
    e.addr = a; e.data = d; e.res = r; e.tag = tag;
    q.push_back(e);
  endfunction

  function automatic logic [2:0] ref_code(logic [6:0] s);
    if (s[3]) return 3'd1;
    if (s[1]) return 3'd2;
    if (s[5] && s[4]) return 3'd3;
    if (s[4]) return 3'd4;
    return 3'd0;
  endfunction

  always @(negedge clk) if (live) begin
    exp_t e;
    logic bad;
    if (q.size() > 0) e = q.pop_front();
    else begin
      e.wr = 0; e.rd = 0; e.dn = 0; e.bz = 0; e.addr = '0; e.data = '0; e.res = '0;
      e.tag = 1; // R1 idle between operations
    end
    bad = (bus_wr !== e.wr) || (bus_rd !== e.rd) || (done !== e.dn) || (busy !== e.bz);
    if (e.wr || e.rd) bad = bad || (bus_addr !== e.addr);
    if (e.wr) bad = bad || (bus_wdata !== e.data);
    if (e.dn) bad = bad || (result !== e.res);
    checks++;
    if (bad) begin
      errors++;
      $display("FAIL R%0d actual wr=%b rd=%b dn=%b bz=%b a=%h d=%h r=%0d expected wr=%b rd=%b dn=%b bz=%b a=%h d=%h r=%0d",
        e.tag, bus_wr, bus_rd, done, busy, bus_addr, bus_wdata, result,
        e.wr, e.rd, e.dn, e.bz, e.addr, e.data, e.res);
    end
  end

  task automatic run_op(logic m, logic [AW-1:0] a, logic dfr, int unsigned blen,
                        int unsigned lim, logic [6:0] err, logic poke);
    logic [AW-1:0] ea;
    int unsigned nread;
    logic [2:0] c;
    ea = m ? DEV : a;
    @(negedge clk); #1;
    fl_busy_len = blen; fl_err = err; poll_limit = CW'(lim);
    req_valid = 1; req_master = m; req_addr = a; req_defer = dfr;
    push(1, 0, 0, ea, 8'h60, 0, 2);                  // R2 setup
    push(1, 0, 0, ea, m ? 8'hF1 : 8'h01, 0, 3);      // R3 confirm
    if (blen >= lim) begin
      for (int i = 0; i < lim; i++) push(0, 1, 0, ea, 0, 0, 4); // R4
      push(0, 0, 1, ea, 0, 3'd5, 9);                 // R9 timeout
    end else begin
      nread = blen + 1;
      for (int i = 0; i < nread; i++) push(0, 1, 0, ea, 0, 0, 4); // R4
      if (dfr) push(0, 0, 1, ea, 0, 3'd0, 8);        // R8 deferred
      else begin
        c = ref_code(err);
        if (c != 0) push(1, 0, 0, ea, 8'h50, 0, 6);  // R6 clear
        push(1, 0, 0, ea, 8'hFF, 0, 7);              // R7 array read
        push(0, 0, 1, ea, 0, c, 5);                  // R5 result
      end
    end
    @(negedge clk); #1;
    req_valid = 0;
    if (poke) begin                                  // R10 start while busy
      @(negedge clk); #1;
      req_valid = 1; req_addr = a ^ 16'h5A5A; req_master = ~m;
      @(negedge clk); #1;
      req_valid = 0;
    end
    while (q.size() > 0) @(negedge clk);
    repeat (2) @(negedge clk);                       // R11 idle after done
  endtask

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (busy !== 0 || done !== 0 || bus_wr !== 0 || bus_rd !== 0) begin
      errors++;
      $display("FAIL R1 actual busy=%b done=%b wr=%b rd=%b expected all 0", busy, done, bus_wr, bus_rd);
    end
    #1 rst_n = 1;
    live = 1;
    run_op(0, 16'h1234, 0, 2, 8, 7'h00, 0);   // R2 R3 R7 block success
    run_op(1, 16'h7777, 0, 0, 8, 7'h00, 0);   // R2 master uses device address
    run_op(0, 16'h2000, 0, 1, 8, 7'h3A, 0);   // R5 voltage masks all
    run_op(0, 16'h2100, 0, 1, 8, 7'h32, 0);   // R5 protect masks sequence
    run_op(0, 16'h2200, 0, 3, 8, 7'h30, 0);   // R5 sequence
    run_op(1, 16'h0000, 0, 0, 8, 7'h10, 0);   // R5 lock failure
    run_op(0, 16'h2300, 0, 0, 8, 7'h20, 0);   // R5 bit 5 alone is success
    run_op(0, 16'h3000, 1, 2, 8, 7'h10, 0);   // R8 deferred keeps error
    run_op(0, 16'h3001, 0, 0, 8, 7'h10, 0);   // R8 R6 later check sees it
    run_op(0, 16'h4000, 0, 5, 5, 7'h00, 0);   // R9 timeout at limit
    run_op(0, 16'h4001, 0, 4, 5, 7'h00, 0);   // R9 ready on last allowed read
    run_op(0, 16'h4002, 0, 0, 1, 7'h00, 0);   // R9 limit of one
    run_op(0, 16'h5000, 0, 3, 8, 7'h02, 1);   // R10 ignored start
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R11 watchdog actual=hung expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule